// File: doc/BRIEF.md
# Predicated Vector Multiply/Divide Unit

This block carries out the integer multiply and divide operations of a predicated vector instruction group on one vector of `VBYTES` bytes. A caller presents an already decoded 3-bit operation code, a 2-bit element size code, two source vectors and a predicate that has one bit per byte, then pulses `start_i`. The first source also serves as the old destination value. The unit raises `busy_o` while it works. It then pulses `done_o` for one cycle, and at that point `vres_o` holds the complete result vector.

All lanes of a multiply are computed in one pass, so a multiply has a fixed latency. Divides run through one shared radix-2 restoring divider. The divider handles one active element at a time, spends one cycle per quotient bit, and skips inactive elements without spending any cycles on them. Operation and size combinations that are not defined are rejected at the interface with a flag and are never started.

Top module: `vec_muldiv_pred`

## Requirements
- R1: Operation code 000 returns, in each active element, the low N bits of the product of the two N-bit source elements.
- R2: Operation code 010 returns the upper N bits of the 2N-bit signed product, and code 011 returns the upper N bits of the 2N-bit unsigned product.
- R3: Size codes 0, 1, 2 and 3 select elements of 8, 16, 32 and 64 bits. Element k occupies the bytes that start at byte k times the element byte count. An element is active only when the predicate bit of its lowest byte is 1, and every other predicate bit is ignored.
- R4: Every inactive element of the result keeps the value of the corresponding element of the first source.
- R5: Code 100 is signed divide and code 101 is unsigned divide, with the first source as dividend. Codes 110 (signed) and 111 (unsigned) are the reversed forms, which take the second source as dividend and the first source as divisor.
- R6: Signed division truncates toward zero and discards the remainder. The most negative value divided by -1 gives the most negative value.
- R7: A zero divisor makes the result element 0.
- R8: A start presented while idle with code 001, or with a divide code and size code 0 or 1, drives `unalloc_o` high in that same cycle. Such a start is not accepted: `busy_o` stays low, no `done_o` follows and `vres_o` does not change.
- R9: After an accepted start, `busy_o` is high from the next cycle until `done_o` rises. `done_o` is high for exactly one cycle, during which `busy_o` is low. A start presented while busy is ignored.
- R10: `done_o` is high in the cycle that follows the L-th rising edge after the edge that samples `start_i`. L is 1 for a multiply, and 1 + A*(W+1) for a divide with A active elements of W bits.
- R11: While the unit is idle and no start is accepted, `vres_o` keeps its value.
- R12: During reset, `busy_o` and `done_o` are low and `vres_o` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start request, sampled while idle |
| op_i | input | 3 | Operation code within the multiply/divide group |
| esize_i | input | 2 | Element size code (8 << code bits) |
| vsrc_a_i | input | VBYTES*8 | First source and old destination vector |
| vsrc_b_i | input | VBYTES*8 | Second source vector |
| pred_i | input | VBYTES | Predicate, one bit per byte |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| unalloc_o | output | 1 | Start rejected as an undefined combination |
| vres_o | output | VBYTES*8 | Result vector |

## Verification
A multiply completes one edge after the edge that samples start. A divide completes 1 + A*(W+1) edges after that edge, which means a divide with no active element also takes one edge. The bench drives its inputs on falling edges and counts falling edges from the first one after start until `done_o` is seen. It compares that count with the formula and reads the result vector only in the done cycle. The rejection flag is combinational, so the bench samples it shortly after driving start. Claims that an input is ignored are checked through the result and `busy_o` in the cycles that follow.

// File: rtl/vmd_pkg.sv
package vmd_pkg;
   typedef enum logic [2:0] {
      OP_MUL   = 3'b000,
      OP_RSV   = 3'b001,
      OP_SMULH = 3'b010,
      OP_UMULH = 3'b011,
      OP_SDIV  = 3'b100,
      OP_UDIV  = 3'b101,
      OP_SDIVR = 3'b110,
      OP_UDIVR = 3'b111
   } vmd_op_e;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_MUL,
      ST_DSEL,
      ST_DRUN
   } vmd_state_e;
endpackage

// File: rtl/vmd_mul_lane.sv
module vmd_mul_lane #(
   parameter int W = 8
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic         sgn,
   input  logic         hi,
   output logic [W-1:0] y
);
   localparam int PW = 2 * W;

   logic [PW-1:0] ext_a, ext_b, prod;

   always_comb begin
      ext_a = {{W{sgn & a[W-1]}}, a};
      ext_b = {{W{sgn & b[W-1]}}, b};
      prod  = ext_a * ext_b;
      y     = hi ? prod[PW-1:W] : prod[W-1:0];
   end
endmodule

// File: rtl/vmd_mul_vector.sv
module vmd_mul_vector import vmd_pkg::*; #(
   parameter int VBYTES = 16
) (
   input  logic [2:0]          op,
   input  logic [1:0]          esize,
   input  logic [VBYTES*8-1:0] a,
   input  logic [VBYTES*8-1:0] b,
   input  logic [VBYTES-1:0]   pred,
   output logic [VBYTES*8-1:0] y
);
   localparam int VW = VBYTES * 8;

   logic sgn, hi;
   assign sgn = (op == OP_SMULH);
   assign hi  = op[1];

   for (genvar s = 0; s < 4; s++) begin : g_sz
      localparam int EW = 8 << s;
      localparam int NL = VBYTES >> s;
      logic [VW-1:0] ys;
      for (genvar l = 0; l < NL; l++) begin : g_ln
         logic [EW-1:0] ly;
         vmd_mul_lane #(.W(EW)) u_lane (
            .a   (a[l*EW +: EW]),
            .b   (b[l*EW +: EW]),
            .sgn (sgn),
            .hi  (hi),
            .y   (ly)
         );
         assign ys[l*EW +: EW] = pred[l*(EW/8)] ? ly : a[l*EW +: EW];
      end
   end

   always_comb begin
      case (esize)
         2'd0:    y = g_sz[0].ys;
         2'd1:    y = g_sz[1].ys;
         2'd2:    y = g_sz[2].ys;
         default: y = g_sz[3].ys;
      endcase
   end
endmodule

// File: rtl/vmd_div_core.sv
module vmd_div_core #(
   parameter int MAXW = 64
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            load,
   input  logic            wide,
   input  logic            sgn,
   input  logic [MAXW-1:0] num,
   input  logic [MAXW-1:0] den,
   output logic            last,
   output logic [MAXW-1:0] quo
);
   localparam int HW = MAXW / 2;
   localparam int CW = $clog2(MAXW) + 1;

   logic [MAXW-1:0] rem_q, q_q, d_q, rem_n, q_n, qraw, qsgn;
   logic [MAXW:0]   shifted, trial;
   logic [CW-1:0]   cnt_q;
   logic            neg_q, dz_q, wide_q;

   function automatic logic [MAXW-1:0] mag(input logic [MAXW-1:0] v,
                                           input logic neg, input logic wd);
      logic [MAXW-1:0] m;
      m = neg ? (~v + 1'b1) : v;
      if (!wd) m = {{HW{1'b0}}, m[HW-1:0]};
      return m;
   endfunction

   logic sn, sd;
   logic [MAXW-1:0] mn, md;
   always_comb begin
      sn = sgn & (wide ? num[MAXW-1] : num[HW-1]);
      sd = sgn & (wide ? den[MAXW-1] : den[HW-1]);
      mn = mag(num, sn, wide);
      md = mag(den, sd, wide);
   end

   always_comb begin
      shifted = {rem_q, q_q[MAXW-1]};
      trial   = shifted - {1'b0, d_q};
      rem_n   = trial[MAXW] ? shifted[MAXW-1:0] : trial[MAXW-1:0];
      q_n     = {q_q[MAXW-2:0], ~trial[MAXW]};
      qraw    = wide_q ? q_n : {{HW{1'b0}}, q_n[HW-1:0]};
      qsgn    = neg_q ? (~qraw + 1'b1) : qraw;
      quo     = dz_q ? '0 : qsgn;
      last    = (cnt_q == CW'(1));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rem_q  <= '0;
         q_q    <= '0;
         d_q    <= '0;
         cnt_q  <= '0;
         neg_q  <= 1'b0;
         dz_q   <= 1'b0;
         wide_q <= 1'b0;
      end else if (load) begin
         rem_q  <= '0;
         q_q    <= wide ? mn : {mn[HW-1:0], {HW{1'b0}}};
         d_q    <= md;
         cnt_q  <= wide ? CW'(MAXW) : CW'(HW);
         neg_q  <= sn ^ sd;
         dz_q   <= (md == '0);
         wide_q <= wide;
      end else if (cnt_q != '0) begin
         rem_q <= rem_n;
         q_q   <= q_n;
         cnt_q <= cnt_q - 1'b1;
      end
   end
endmodule

// File: rtl/vec_muldiv_pred.sv
module vec_muldiv_pred import vmd_pkg::*; #(
   parameter int VBYTES = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start_i,
   input  logic [2:0]          op_i,
   input  logic [1:0]          esize_i,
   input  logic [VBYTES*8-1:0] vsrc_a_i,
   input  logic [VBYTES*8-1:0] vsrc_b_i,
   input  logic [VBYTES-1:0]   pred_i,
   output logic                busy_o,
   output logic                done_o,
   output logic                unalloc_o,
   output logic [VBYTES*8-1:0] vres_o
);
   localparam int VW   = VBYTES * 8;
   localparam int OFFW = $clog2(VBYTES);

   if (VBYTES < 8 || (VBYTES & (VBYTES - 1)) != 0) begin : g_bad_vbytes
      $error("VBYTES must be a power of two of at least 8");
   end

   vmd_state_e        state_q;
   logic [2:0]        op_q;
   logic [1:0]        size_q;
   logic [VW-1:0]     a_q, b_q, res_q, mul_y;
   logic [VBYTES-1:0] pred_q, pend_q, init_mask;
   logic [OFFW-1:0]   off_q, first;
   logic [63:0]       el_a, el_b, num, den, quo;
   logic              legal, accept, div_load, div_last;

   assign legal     = !(op_i == OP_RSV) && !(op_i[2] && !esize_i[1]);
   assign accept    = start_i && (state_q == ST_IDLE) && legal;
   assign unalloc_o = start_i && (state_q == ST_IDLE) && !legal;
   assign busy_o    = (state_q != ST_IDLE);
   assign vres_o    = res_q;

   always_comb begin
      for (int b = 0; b < VBYTES; b++)
         init_mask[b] = pred_i[b] && ((b % (1 << int'(esize_i))) == 0);
   end

   always_comb begin
      first = '0;
      for (int i = VBYTES - 1; i >= 0; i--)
         if (pend_q[i]) first = OFFW'(i);
   end

   always_comb begin
      if (size_q[0]) begin
         el_a = a_q[{first, 3'b000} +: 64];
         el_b = b_q[{first, 3'b000} +: 64];
      end else begin
         el_a = {32'b0, a_q[{first, 3'b000} +: 32]};
         el_b = {32'b0, b_q[{first, 3'b000} +: 32]};
      end
      num = op_q[1] ? el_b : el_a;
      den = op_q[1] ? el_a : el_b;
   end

   assign div_load = (state_q == ST_DSEL) && (pend_q != '0);

   vmd_mul_vector #(.VBYTES(VBYTES)) u_mul (
      .op    (op_q),
      .esize (size_q),
      .a     (a_q),
      .b     (b_q),
      .pred  (pred_q),
      .y     (mul_y)
   );

   vmd_div_core #(.MAXW(64)) u_div (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (div_load),
      .wide  (size_q[0]),
      .sgn   (~op_q[0]),
      .num   (num),
      .den   (den),
      .last  (div_last),
      .quo   (quo)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         done_o  <= 1'b0;
         op_q    <= '0;
         size_q  <= '0;
         a_q     <= '0;
         b_q     <= '0;
         res_q   <= '0;
         pred_q  <= '0;
         pend_q  <= '0;
         off_q   <= '0;
      end else begin
         done_o <= 1'b0;
         case (state_q)
            ST_IDLE: if (accept) begin
               op_q    <= op_i;
               size_q  <= esize_i;
               a_q     <= vsrc_a_i;
               b_q     <= vsrc_b_i;
               pred_q  <= pred_i;
               pend_q  <= init_mask;
               res_q   <= vsrc_a_i;
               state_q <= op_i[2] ? ST_DSEL : ST_MUL;
            end
            ST_MUL: begin
               res_q   <= mul_y;
               done_o  <= 1'b1;
               state_q <= ST_IDLE;
            end
            ST_DSEL: if (pend_q == '0) begin
               done_o  <= 1'b1;
               state_q <= ST_IDLE;
            end else begin
               off_q         <= first;
               pend_q[first] <= 1'b0;
               state_q       <= ST_DRUN;
            end
            default: if (div_last) begin
               if (size_q[0]) res_q[{off_q, 3'b000} +: 64] <= quo;
               else           res_q[{off_q, 3'b000} +: 32] <= quo[31:0];
               state_q <= ST_DSEL;
            end
         endcase
      end
   end
endmodule

// File: rtl/vmd_checker.sv
module vmd_checker #(
   parameter int VBYTES = 16
) (
   input logic                clk,
   input logic                rst_n,
   input logic                start_i,
   input logic [2:0]          op_i,
   input logic [1:0]          esize_i,
   input logic [VBYTES*8-1:0] vsrc_a_i,
   input logic [VBYTES*8-1:0] vsrc_b_i,
   input logic [VBYTES-1:0]   pred_i,
   input logic                busy_o,
   input logic                done_o,
   input logic                unalloc_o,
   input logic [VBYTES*8-1:0] vres_o
);
   assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   assert_done_not_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !(done_o && busy_o));

   assert_accept_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !busy_o && !unalloc_o) |=> busy_o);

   assert_unalloc_no_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && unalloc_o) |=> (!busy_o && !done_o && $stable(vres_o)));

   assert_unalloc_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      unalloc_o |-> !busy_o);

   assert_mul_latency_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !busy_o && !unalloc_o && !op_i[2]) |=> ##1 done_o);

   assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && !start_i) |=> $stable(vres_o));
endmodule

bind vec_muldiv_pred vmd_checker #(.VBYTES(VBYTES)) u_vmd_chk (.*);

// File: tb/vec_muldiv_pred_test.sv
module vec_muldiv_pred_test;
   localparam int VB = 16;
   localparam int VW = VB * 8;

   typedef struct packed {
      logic [2:0]    op;
      logic [1:0]    sz;
      logic [VW-1:0] a;
      logic [VW-1:0] b;
      logic [VB-1:0] p;
   } vec_t;

   localparam int NV = 12;
   localparam vec_t TBL [NV] = '{
      '{3'b000, 2'd0, 128'h0102_0304_0506_0708_090A_0B0C_0D0E_0F10,
                      128'hFF10_2030_4050_6070_8090_A0B0_C0D0_E0F0, 16'hFFFF},
      '{3'b010, 2'd1, 128'h8000_7FFF_FFFF_0001_1234_ABCD_8000_0003,
                      128'h8000_7FFF_0002_FFFF_5678_1111_7FFF_FFFD, 16'h5555},
      '{3'b011, 2'd1, 128'h8000_7FFF_FFFF_0001_1234_ABCD_8000_0003,
                      128'h8000_7FFF_0002_FFFF_5678_1111_7FFF_FFFD, 16'h1111},
      '{3'b011, 2'd3, 128'hFFFF_FFFF_FFFF_FFFF_0000_0001_0000_0000,
                      128'hFFFF_FFFF_FFFF_FFFF_0000_0001_0000_0000, 16'h0101},
      '{3'b010, 2'd3, 128'hFFFF_FFFF_FFFF_FFFF_0000_0001_0000_0000,
                      128'hFFFF_FFFF_FFFF_FFFF_0000_0001_0000_0000, 16'h0100},
      '{3'b100, 2'd2, 128'h8000_0000_FFFF_FFF9_0000_0007_0000_0064,
                      128'hFFFF_FFFF_0000_0002_FFFF_FFFE_0000_0000, 16'h1111},
      '{3'b101, 2'd2, 128'h8000_0000_FFFF_FFF9_0000_0007_0000_0064,
                      128'hFFFF_FFFF_0000_0002_FFFF_FFFE_0000_0000, 16'h1011},
      '{3'b110, 2'd2, 128'h0000_0003_0000_0000_FFFF_FFFC_0000_0005,
                      128'h0000_000A_0000_0009_0000_0011_0000_0010, 16'h1111},
      '{3'b111, 2'd3, 128'h0000_0000_0000_0003_0000_0000_0000_0000,
                      128'hFFFF_FFFF_FFFF_FFFF_1234_5678_9ABC_DEF0, 16'h0101},
      '{3'b100, 2'd3, 128'h8000_0000_0000_0000_FFFF_FFFF_FFFF_FF9C,
                      128'hFFFF_FFFF_FFFF_FFFF_0000_0000_0000_0007, 16'h0101},
      '{3'b100, 2'd2, 128'h8000_0000_FFFF_FFF9_0000_0007_0000_0064,
                      128'hFFFF_FFFF_0000_0002_FFFF_FFFE_0000_0000, 16'h2222},
      '{3'b000, 2'd2, 128'h0102_0304_0506_0708_090A_0B0C_0D0E_0F10,
                      128'hFF10_2030_4050_6070_8090_A0B0_C0D0_E0F0, 16'hEEEE}
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [2:0]    op = '0;
   logic [1:0]    esz = '0;
   logic [VW-1:0] va = '0, vb = '0;
   logic [VB-1:0] pr = '0;
   logic          busy, done, unalloc;
   logic [VW-1:0] vres;

   int checks = 0;
   int errors = 0;

   always #5 clk = ~clk;

   vec_muldiv_pred #(.VBYTES(VB)) uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .start_i   (start),
      .op_i      (op),
      .esize_i   (esz),
      .vsrc_a_i  (va),
      .vsrc_b_i  (vb),
      .pred_i    (pr),
      .busy_o    (busy),
      .done_o    (done),
      .unalloc_o (unalloc),
      .vres_o    (vres)
   );

   task automatic chk(input bit ok, input string req,
                      input logic [VW-1:0] act, input logic [VW-1:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic logic [VW-1:0] model(input logic [2:0] mop, input logic [1:0] msz,
                                           input logic [VW-1:0] a, input logic [VW-1:0] b,
                                           input logic [VB-1:0] p, output int lat);
      int w, n, act;
      logic [63:0] mask, x, y, nu, de, res;
      longint snu, sde, sx, sy;
      logic [127:0] ex, ey, prd;
      logic [VW-1:0] r;
      w = 8 << msz;
      n = VB >> msz;
      act = 0;
      r = a;
      mask = (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
      for (int i = 0; i < n; i++) begin
         if (p[i * (w / 8)]) begin
            act++;
            x  = 64'(a >> (i * w)) & mask;
            y  = 64'(b >> (i * w)) & mask;
            sx = longint'(x << (64 - w)) >>> (64 - w);
            sy = longint'(y << (64 - w)) >>> (64 - w);
            if (!mop[2]) begin
               ex  = (mop == 3'b010) ? {{64{sx[63]}}, sx} : {64'b0, x};
               ey  = (mop == 3'b010) ? {{64{sy[63]}}, sy} : {64'b0, y};
               prd = ex * ey;
               res = (mop == 3'b000) ? prd[63:0] : 64'(prd >> w);
            end else begin
               nu  = mop[1] ? y : x;
               de  = mop[1] ? x : y;
               snu = mop[1] ? sy : sx;
               sde = mop[1] ? sx : sy;
               if (de == 64'd0) res = 64'd0;
               else if (mop[0]) res = nu / de;
               else if (w == 64 && snu == 64'sh8000_0000_0000_0000 && sde == -64'sd1)
                  res = 64'(snu);
               else res = 64'(snu / sde);
            end
            res = res & mask;
            r = (r & ~({64'b0, mask} << (i * w))) | ({64'b0, res} << (i * w));
         end
      end
      lat = mop[2] ? 1 + act * (w + 1) : 1;
      return r;
   endfunction

   task automatic run(input logic [2:0] rop, input logic [1:0] rsz,
                      input logic [VW-1:0] ra, input logic [VW-1:0] rb,
                      input logic [VB-1:0] rp, input int poke,
                      output logic [VW-1:0] res, output int lat, output bit busy0);
      @(negedge clk);
      op = rop; esz = rsz; va = ra; vb = rb; pr = rp; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      lat = 0;
      busy0 = busy;
      while (!done && lat < 5000) begin
         @(negedge clk);
         lat++;
         if (lat == poke) begin
            start = 1'b1; op = 3'b000; va = ~ra; pr = '1;
         end else begin
            start = 1'b0;
         end
      end
      start = 1'b0;
      res = vres;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic [VW-1:0] got, exp, held;
      int lat, elat;
      bit b0;

      // R12 reset state
      repeat (3) @(negedge clk);
      chk(busy == 1'b0, "R12 busy in reset", VW'(busy), '0);
      chk(done == 1'b0, "R12 done in reset", VW'(done), '0);
      chk(vres == '0, "R12 result in reset", vres, '0);
      rst_n = 1'b1;

      // vector table
      for (int k = 0; k < NV; k++) begin
         exp = model(TBL[k].op, TBL[k].sz, TBL[k].a, TBL[k].b, TBL[k].p, elat);
         run(TBL[k].op, TBL[k].sz, TBL[k].a, TBL[k].b, TBL[k].p, -1, got, lat, b0);
         if (TBL[k].op[2])
            chk(got == exp, "R5 R6 R7 R3 R4 divide vector", got, exp);
         else
            chk(got == exp, "R1 R2 R3 R4 multiply vector", got, exp);
         chk(lat == elat, "R10 latency", VW'(lat), VW'(elat));
         chk(b0 == 1'b1, "R9 busy after start", VW'(b0), VW'(1));
      end

      // R1 R2 hand values in byte lane 0
      run(3'b011, 2'd0, {{15{8'hAA}}, 8'hFF}, {{15{8'h55}}, 8'h02}, 16'h0001, -1, got, lat, b0);
      chk(got == {{15{8'hAA}}, 8'h01}, "R2 unsigned high byte", got, {{15{8'hAA}}, 8'h01});
      run(3'b010, 2'd0, {{15{8'hAA}}, 8'hFF}, {{15{8'h55}}, 8'h02}, 16'h0001, -1, got, lat, b0);
      chk(got == {{15{8'hAA}}, 8'hFF}, "R2 signed high byte", got, {{15{8'hAA}}, 8'hFF});
      run(3'b000, 2'd0, {{15{8'hAA}}, 8'hFF}, {{15{8'h55}}, 8'h02}, 16'h0001, -1, got, lat, b0);
      chk(got == {{15{8'hAA}}, 8'hFE}, "R1 low byte", got, {{15{8'hAA}}, 8'hFE});

      // R6 hand value: -7 / 2 = -3, 34 cycles
      run(3'b100, 2'd2, {96'h0, 32'hFFFF_FFF9}, {96'h0, 32'h2}, 16'h0001, -1, got, lat, b0);
      chk(got == {96'h0, 32'hFFFF_FFFD}, "R6 truncation", got, {96'h0, 32'hFFFF_FFFD});
      chk(lat == 34, "R10 single 32-bit divide latency", VW'(lat), VW'(34));

      // R9 start while busy is ignored
      exp = model(TBL[5].op, TBL[5].sz, TBL[5].a, TBL[5].b, TBL[5].p, elat);
      run(TBL[5].op, TBL[5].sz, TBL[5].a, TBL[5].b, TBL[5].p, 5, got, lat, b0);
      chk(got == exp, "R9 start while busy ignored result", got, exp);
      chk(lat == elat, "R9 start while busy ignored latency", VW'(lat), VW'(elat));

      // R8 unallocated combinations
      for (int u = 0; u < 3; u++) begin
         held = vres;
         @(negedge clk);
         start = 1'b1; va = ~held; vb = '1; pr = '1;
         op  = (u == 0) ? 3'b101 : (u == 1) ? 3'b110 : 3'b001;
         esz = (u == 0) ? 2'd1 : (u == 1) ? 2'd0 : 2'd2;
         #1;
         chk(unalloc == 1'b1, "R8 unalloc flag", VW'(unalloc), VW'(1));
         @(negedge clk);
         start = 1'b0;
         chk(busy == 1'b0, "R8 not started", VW'(busy), '0);
         repeat (2) @(negedge clk);
         chk(done == 1'b0 && vres == held, "R8 no done and result unchanged", vres, held);
      end

      // R11 result holds while idle
      held = vres;
      for (int j = 0; j < 5; j++) begin
         @(negedge clk);
         va = {4{32'h1357_9BDF}} ^ VW'(j); vb = ~va; op = 3'b000; pr = '1;
      end
      @(negedge clk);
      chk(vres == held && done == 1'b0, "R11 idle hold", vres, held);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule